// File: doc/BRIEF.md
# Message Buffer Transfer Engine

This block moves one message object at a time between a bank of staging registers that the CPU can see and a 32-entry object store. The CPU writes the staging fields and a command byte through a simple register strobe port. It then posts a message number, which starts a transfer. The store can only be written one whole object at a time. For that reason every transfer that writes the store first fetches the addressed object, merges the selected staging fields into it, and writes the complete object back.

The command byte chooses the direction of the transfer and which object fields take part. It can also set the transmit request flag, or clear the new-data and interrupt-pending flags, as a side effect. A busy output is high for the whole transfer. Message numbers outside 1..32 finish after one busy cycle and do not touch the store.

Top module: `mbx_xfer_engine`

## Requirements
- R1: A message number posted on `req_valid` while `busy` is 0 makes `busy` 1 for exactly two cycles, starting at the next clock edge. When `busy` returns to 0, the object store and the staging registers hold the results of the transfer.
- R2: A posted number of 0 or above 32 makes `busy` 1 for one cycle only. It changes neither the object store nor any staging register.
- R3: A request posted while `busy` is 1 is dropped. It starts no transfer and it does not stretch the busy period.
- R4: With command bit 7 = 1 (write), the staging fields selected by the command are merged into the fetched object, and the whole object is written back. The bits are: bit 6 selects the mask, bit 5 the arbitration word, bit 4 the control word together with the three flags, bit 1 data half A and bit 0 data half B. Unselected fields keep their stored values.
- R5: Data moves in two 32-bit halves. A holds bytes 0 to 3 and B holds bytes 4 to 7. Selecting one half never alters the other half.
- R6: On a write, command bit 2 sets the object's transmit-request flag. Command 0x87 updates both halves and sets the flag, and leaves the mask, arbitration and control fields as stored.
- R7: With bit 7 = 0 (read), the selected object fields are copied into the staging registers, using the same field bits as R4. Unselected staging fields keep their values.
- R8: On a read, bit 3 clears the object's interrupt-pending flag and bit 2 clears its new-data flag. The staging flags receive the values from before the clear. Command 0x7F reads every field and clears both flags.
- R9: Reset sets `busy`, the command register, all staging registers and the flags of every object to 0.
- R10: A CPU write with `cpu_sel` = 0, 1, 2, 3, 4 or 5 loads the command byte, the mask, the arbitration word, the control word, data A or data B respectively. For code 3, `cpu_wdata` bits 15:0 are the control word and bits 18:16 are {interrupt-pending, new-data, transmit-request}.
- R11: The staging registers change only through a CPU write or at the end of a read transfer. A write transfer leaves them as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Staging register write strobe |
| cpu_sel | input | 3 | Staging field code (R10) |
| cpu_wdata | input | 32 | Staging write data |
| req_valid | input | 1 | Post a message number |
| req_num | input | 6 | Message number, valid range 1..32 |
| busy | output | 1 | Transfer in progress |
| stg_cmd | output | 8 | Command byte |
| stg_msk | output | 32 | Staging mask field |
| stg_arb | output | 32 | Staging arbitration field |
| stg_ctl | output | 16 | Staging control field |
| stg_flags | output | 3 | Staging flags {interrupt-pending, new-data, transmit-request} |
| stg_data_a | output | 32 | Staging data half A |
| stg_data_b | output | 32 | Staging data half B |

## Verification
A valid request raises `busy` at the first clock edge after the post. The object is fetched at the second edge. The write-back and the staging load both land at the third edge, which is also when `busy` falls. An invalid request drops `busy` at the second edge. The bench drives inputs on falling edges and samples `busy` at the falling edge after each of these rising edges. It compares the staging registers only after `busy` is seen low. The store is checked by a full read without clears once each transfer is done, so every result is observed exactly where it is due and never earlier.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MSK_W  = 32;
  localparam int ARB_W  = 32;
  localparam int CTL_W  = 16;
  localparam int HALF_W = 32;
  localparam int FLG_W  = 3;
  localparam int CPU_W  = 32;
  localparam int CMD_W  = 8;

  typedef struct packed {
    logic intpnd;
    logic newdat;
    logic txrq;
  } flags_t;

  typedef struct packed {
    logic [MSK_W-1:0]  msk;
    logic [ARB_W-1:0]  arb;
    logic [CTL_W-1:0]  ctl;
    logic [HALF_W-1:0] dat_b;
    logic [HALF_W-1:0] dat_a;
  } body_t;

  typedef struct packed {
    body_t  body;
    flags_t flg;
  } obj_t;

  // bit order matches the command byte, bit 7 first
  typedef struct packed {
    logic dir;
    logic use_msk;
    logic use_arb;
    logic use_ctl;
    logic clr_ip;
    logic tx_nd;
    logic use_a;
    logic use_b;
  } cmd_t;

  typedef enum logic [2:0] {
    SEL_CMD = 3'd0,
    SEL_MSK = 3'd1,
    SEL_ARB = 3'd2,
    SEL_CTL = 3'd3,
    SEL_DA  = 3'd4,
    SEL_DB  = 3'd5
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MERGE = 2'd2,
    ST_NOP   = 2'd3
  } st_e;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram
  import mbx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  obj_t          wdata,
  output obj_t          rdata
);
  body_t  mem [DEPTH];
  flags_t flg_q [DEPTH];
  body_t  rd_body_q;
  flags_t rd_flg_q;

  // object body: plain storage, not reset
  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[addr] <= wdata.body;
    end
    if (en && !we) begin
      rd_body_q <= mem[addr];
    end
  end

  // status flags: reset with the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        flg_q[i] <= '0;
      end
    end else if (en && we) begin
      flg_q[addr] <= wdata.flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_flg_q <= '0;
    end else if (en && !we) begin
      rd_flg_q <= flg_q[addr];
    end
  end

  assign rdata = {rd_body_q, rd_flg_q};
endmodule

// File: rtl/mbx_merge.sv
module mbx_merge
  import mbx_pkg::*;
(
  input  cmd_t cmd,
  input  obj_t stored,
  input  obj_t stg,
  output obj_t merged,
  output logic wb_need
);
  always_comb begin
    merged  = stored;
    wb_need = 1'b0;
    if (cmd.dir) begin
      wb_need = 1'b1;
      if (cmd.use_msk) merged.body.msk   = stg.body.msk;
      if (cmd.use_arb) merged.body.arb   = stg.body.arb;
      if (cmd.use_ctl) begin
        merged.body.ctl = stg.body.ctl;
        merged.flg      = stg.flg;
      end
      if (cmd.use_a)   merged.body.dat_a = stg.body.dat_a;
      if (cmd.use_b)   merged.body.dat_b = stg.body.dat_b;
      if (cmd.tx_nd)   merged.flg.txrq   = 1'b1;
    end else begin
      if (cmd.clr_ip) begin
        merged.flg.intpnd = 1'b0;
        wb_need           = 1'b1;
      end
      if (cmd.tx_nd) begin
        merged.flg.newdat = 1'b0;
        wb_need           = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_stage.sv
module mbx_stage
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [2:0]       cpu_sel,
  input  logic [CPU_W-1:0] cpu_wdata,
  input  logic             load,
  input  cmd_t             load_cmd,
  input  obj_t             src,
  output cmd_t             cmd_q,
  output obj_t             stg_q
);
  cmd_t cmd_n;
  obj_t stg_n;
  logic upd;

  always_comb begin
    cmd_n = cmd_q;
    stg_n = stg_q;
    if (cpu_we) begin
      case (sel_e'(cpu_sel))
        SEL_CMD: cmd_n            = cmd_t'(cpu_wdata[CMD_W-1:0]);
        SEL_MSK: stg_n.body.msk   = cpu_wdata[MSK_W-1:0];
        SEL_ARB: stg_n.body.arb   = cpu_wdata[ARB_W-1:0];
        SEL_CTL: begin
          stg_n.body.ctl = cpu_wdata[CTL_W-1:0];
          stg_n.flg      = flags_t'(cpu_wdata[CTL_W+FLG_W-1:CTL_W]);
        end
        SEL_DA:  stg_n.body.dat_a = cpu_wdata[HALF_W-1:0];
        SEL_DB:  stg_n.body.dat_b = cpu_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
    if (load) begin
      if (load_cmd.use_msk) stg_n.body.msk = src.body.msk;
      if (load_cmd.use_arb) stg_n.body.arb = src.body.arb;
      if (load_cmd.use_ctl) begin
        stg_n.body.ctl = src.body.ctl;
        stg_n.flg      = src.flg;
      end
      if (load_cmd.use_a)   stg_n.body.dat_a = src.body.dat_a;
      if (load_cmd.use_b)   stg_n.body.dat_b = src.body.dat_b;
    end
    upd = cpu_we || load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      stg_q <= '0;
    end else if (upd) begin
      cmd_q <= cmd_n;
      stg_q <= stg_n;
    end
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int OBJ_CNT = 32,
  localparam int AW    = $clog2(OBJ_CNT),
  localparam int NUM_W = $clog2(OBJ_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [NUM_W-1:0] req_num,
  input  cmd_t             cmd_in,
  input  logic             wb_need,
  output logic             busy,
  output logic             ram_en,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output cmd_t             cmd_r,
  output logic             stg_load
);
  st_e           st_q, st_n;
  logic [AW-1:0] addr_q;
  logic          accept, num_ok;

  always_comb begin
    num_ok = (req_num != '0) && (req_num <= NUM_W'(OBJ_CNT));
    accept = (st_q == ST_IDLE) && req_valid;
    st_n   = st_q;
    case (st_q)
      ST_IDLE:  if (req_valid) st_n = num_ok ? ST_FETCH : ST_NOP;
      ST_FETCH: st_n = ST_MERGE;
      ST_MERGE: st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cmd_r  <= '0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        addr_q <= AW'(req_num - NUM_W'(1));
        cmd_r  <= cmd_in;
      end
    end
  end

  always_comb begin
    busy     = (st_q != ST_IDLE);
    ram_we   = (st_q == ST_MERGE) && wb_need;
    ram_en   = (st_q == ST_FETCH) || ram_we;
    ram_addr = addr_q;
    stg_load = (st_q == ST_MERGE) && !cmd_r.dir;
  end
endmodule

// File: rtl/mbx_xfer_engine.sv
module mbx_xfer_engine
  import mbx_pkg::*;
#(
  parameter int OBJ_CNT = 32,
  localparam int AW    = $clog2(OBJ_CNT),
  localparam int NUM_W = $clog2(OBJ_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_sel,
  input  logic [CPU_W-1:0]  cpu_wdata,
  input  logic              req_valid,
  input  logic [NUM_W-1:0]  req_num,
  output logic              busy,
  output logic [CMD_W-1:0]  stg_cmd,
  output logic [MSK_W-1:0]  stg_msk,
  output logic [ARB_W-1:0]  stg_arb,
  output logic [CTL_W-1:0]  stg_ctl,
  output logic [FLG_W-1:0]  stg_flags,
  output logic [HALF_W-1:0] stg_data_a,
  output logic [HALF_W-1:0] stg_data_b
);
  cmd_t          cmd_q, cmd_r;
  obj_t          stg_q, ram_rdata, merged;
  logic          wb_need, stg_load;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;

  mbx_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .load      (stg_load),
    .load_cmd  (cmd_r),
    .src       (ram_rdata),
    .cmd_q     (cmd_q),
    .stg_q     (stg_q)
  );

  mbx_seq #(.OBJ_CNT(OBJ_CNT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_num   (req_num),
    .cmd_in    (cmd_q),
    .wb_need   (wb_need),
    .busy      (busy),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .cmd_r     (cmd_r),
    .stg_load  (stg_load)
  );

  mbx_merge u_merge (
    .cmd     (cmd_r),
    .stored  (ram_rdata),
    .stg     (stg_q),
    .merged  (merged),
    .wb_need (wb_need)
  );

  mbx_ram #(.DEPTH(OBJ_CNT)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (merged),
    .rdata (ram_rdata)
  );

  assign stg_cmd    = cmd_q;
  assign stg_msk    = stg_q.body.msk;
  assign stg_arb    = stg_q.body.arb;
  assign stg_ctl    = stg_q.body.ctl;
  assign stg_flags  = stg_q.flg;
  assign stg_data_a = stg_q.body.dat_a;
  assign stg_data_b = stg_q.body.dat_b;
endmodule

// File: rtl/mbx_xfer_engine_chk.sv
module mbx_xfer_engine_chk
  import mbx_pkg::*;
#(
  parameter int OBJ_CNT = 32,
  localparam int AW    = $clog2(OBJ_CNT),
  localparam int NUM_W = $clog2(OBJ_CNT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [2:0]        cpu_sel,
  input logic              req_valid,
  input logic [NUM_W-1:0]  req_num,
  input logic              busy,
  input logic [CMD_W-1:0]  stg_cmd,
  input logic [MSK_W-1:0]  stg_msk,
  input logic [ARB_W-1:0]  stg_arb,
  input logic [CTL_W-1:0]  stg_ctl,
  input logic [FLG_W-1:0]  stg_flags,
  input logic [HALF_W-1:0] stg_data_a,
  input logic [HALF_W-1:0] stg_data_b,
  input logic              ram_en,
  input logic              ram_we,
  input logic [AW-1:0]     ram_addr
);
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  p_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && ((req_num == '0) || (req_num > NUM_W'(OBJ_CNT))))
      |=> (busy && !ram_en) ##1 (!busy && !ram_en));

  p_rmw_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_en && !ram_we));

  p_rmw_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == $past(ram_addr)));

  p_stg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cpu_we) |=> ($stable(stg_msk) && $stable(stg_arb) &&
      $stable(stg_ctl) && $stable(stg_flags) && $stable(stg_data_a) &&
      $stable(stg_data_b)));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && (cpu_sel == 3'd0)) |=> $stable(stg_cmd));

  // R4: a store write always sits inside an enabled access
  always_comb begin
    if (rst_n) begin
      a_we_en_r4: assert (!ram_we || ram_en);
    end
  end
endmodule

bind mbx_xfer_engine mbx_xfer_engine_chk #(.OBJ_CNT(OBJ_CNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_we     (cpu_we),
  .cpu_sel    (cpu_sel),
  .req_valid  (req_valid),
  .req_num    (req_num),
  .busy       (busy),
  .stg_cmd    (stg_cmd),
  .stg_msk    (stg_msk),
  .stg_arb    (stg_arb),
  .stg_ctl    (stg_ctl),
  .stg_flags  (stg_flags),
  .stg_data_a (stg_data_a),
  .stg_data_b (stg_data_b),
  .ram_en     (ram_en),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr)
);

// File: tb/mbx_xfer_engine_test.sv
`timescale 1ns/1ps
module mbx_xfer_engine_test;
  localparam int OBJ_CNT = 32;
  localparam int NUM_W   = 6;
  localparam int NVEC    = 12;

  // {command byte, message number}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'h87, 6'd1},   // R6: both halves plus transmit request
    {8'hC0, 6'd2},   // R4: mask only
    {8'hA2, 6'd17},  // R4 R5: arbitration and half A
    {8'h91, 6'd32},  // R4 R5: control and half B
    {8'h7F, 6'd1},   // R8: full read with both clears
    {8'h90, 6'd17},  // R4: control with flags
    {8'h0C, 6'd17},  // R8: clears only, no field load
    {8'h12, 6'd32},  // R7: control and half A
    {8'h84, 6'd2},   // R6: transmit request only
    {8'h48, 6'd2},   // R7 R8: mask plus interrupt clear
    {8'h7F, 6'd32},  // R8
    {8'h81, 6'd17}   // R5: half B only
  };

  logic              clk, rst_n, cpu_we, req_valid;
  logic [2:0]        cpu_sel;
  logic [31:0]       cpu_wdata;
  logic [NUM_W-1:0]  req_num;
  logic              busy;
  logic [7:0]        stg_cmd;
  logic [31:0]       stg_msk, stg_arb, stg_data_a, stg_data_b;
  logic [15:0]       stg_ctl;
  logic [2:0]        stg_flags;

  mbx_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .req_valid(req_valid), .req_num(req_num),
    .busy(busy), .stg_cmd(stg_cmd), .stg_msk(stg_msk), .stg_arb(stg_arb),
    .stg_ctl(stg_ctl), .stg_flags(stg_flags), .stg_data_a(stg_data_a),
    .stg_data_b(stg_data_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // expected object store and staging, built from the requirements
  logic [31:0] m_msk [1:OBJ_CNT];
  logic [31:0] m_arb [1:OBJ_CNT];
  logic [31:0] m_a   [1:OBJ_CNT];
  logic [31:0] m_b   [1:OBJ_CNT];
  logic [15:0] m_ctl [1:OBJ_CNT];
  logic [2:0]  m_fl  [1:OBJ_CNT];
  logic [31:0] s_msk, s_arb, s_a, s_b;
  logic [15:0] s_ctl;
  logic [2:0]  s_fl;
  logic [7:0]  s_cmd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic load_stage(input int seed);
    s_msk = 32'h1357_0000 ^ (seed * 32'h0001_0203);
    s_arb = 32'h2468_ACE0 + seed * 32'h0100_0011;
    s_ctl = 16'h5A00 ^ 16'(seed * 7);
    s_fl  = 3'(seed * 3 + 1);
    s_a   = 32'hA0A0_0000 | seed;
    s_b   = 32'hB0B0_0000 | (seed << 8);
    cpu_wr(3'd1, s_msk);
    cpu_wr(3'd2, s_arb);
    cpu_wr(3'd3, {13'd0, s_fl, s_ctl});
    cpu_wr(3'd4, s_a);
    cpu_wr(3'd5, s_b);
  endtask

  task automatic check_stage(input string tag);
    chk({tag, " cmd"},   64'(stg_cmd),    64'(s_cmd));
    chk({tag, " mask"},  64'(stg_msk),    64'(s_msk));
    chk({tag, " arb"},   64'(stg_arb),    64'(s_arb));
    chk({tag, " ctl"},   64'({stg_flags, stg_ctl}), 64'({s_fl, s_ctl}));
    chk({tag, " data"},  {stg_data_b, stg_data_a}, {s_b, s_a});
  endtask

  // post a transfer and follow busy edge by edge (R1, R2)
  task automatic xfer(input logic [7:0] cmd, input int num);
    bit ok;
    ok = (num >= 1) && (num <= OBJ_CNT);
    cpu_wr(3'd0, cmd);
    s_cmd = cmd;
    req_valid = 1'b1; req_num = NUM_W'(num);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ok ? "R1 busy edge1" : "R2 busy edge1", 64'(busy), 64'd1);
    @(negedge clk);
    if (ok) begin
      chk("R1 busy edge2", 64'(busy), 64'd1);
      @(negedge clk);
      chk("R1 busy edge3", 64'(busy), 64'd0);
      if (cmd[7]) begin
        if (cmd[6]) m_msk[num] = s_msk;
        if (cmd[5]) m_arb[num] = s_arb;
        if (cmd[4]) begin m_ctl[num] = s_ctl; m_fl[num] = s_fl; end
        if (cmd[1]) m_a[num] = s_a;
        if (cmd[0]) m_b[num] = s_b;
        if (cmd[2]) m_fl[num][0] = 1'b1;
      end else begin
        if (cmd[6]) s_msk = m_msk[num];
        if (cmd[5]) s_arb = m_arb[num];
        if (cmd[4]) begin s_ctl = m_ctl[num]; s_fl = m_fl[num]; end
        if (cmd[1]) s_a = m_a[num];
        if (cmd[0]) s_b = m_b[num];
        if (cmd[3]) m_fl[num][2] = 1'b0;
        if (cmd[2]) m_fl[num][1] = 1'b0;
      end
    end else begin
      chk("R2 busy edge2", 64'(busy), 64'd0);
    end
  endtask

  // full read without clears, then compare against the model
  task automatic verify_obj(input int num);
    xfer(8'h73, num);
    chk("R4 R7 mask",           64'(stg_msk), 64'(m_msk[num]));
    chk("R4 R7 arb",            64'(stg_arb), 64'(m_arb[num]));
    chk("R4 R7 ctl",            64'(stg_ctl), 64'(m_ctl[num]));
    chk("R6 R8 object flags",   64'(stg_flags), 64'(m_fl[num]));
    chk("R5 data halves",       {stg_data_b, stg_data_a}, {m_b[num], m_a[num]});
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cpu_we = 1'b0; cpu_sel = '0; cpu_wdata = '0; req_valid = 1'b0; req_num = '0;
    for (int i = 1; i <= OBJ_CNT; i++) m_fl[i] = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 busy",    64'(busy), 64'd0);
    chk("R9 cmd",     64'(stg_cmd), 64'd0);
    chk("R9 staging", {stg_msk, stg_arb}, 64'd0);
    chk("R9 staging ctl/data", {stg_ctl, stg_flags, stg_data_a}, 64'd0);

    // R9: flags of an untouched object read back as zero
    xfer(8'h10, 5);
    chk("R9 object flags", 64'(stg_flags), 64'd0);

    // bring the objects under test to known contents
    begin
      int init_num [4] = '{1, 2, 17, 32};
      for (int k = 0; k < 4; k++) begin
        load_stage(40 + k);
        xfer(8'hF3, init_num[k]);
        check_stage("R10 R11 staging after write");
        verify_obj(init_num[k]);
      end
    end

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      load_stage(i + 3);
      xfer(VEC[i][13:6], int'(VEC[i][5:0]));
      check_stage(VEC[i][13] ? "R11 staging kept" : "R7 staging loaded");
      verify_obj(int'(VEC[i][5:0]));
    end

    // R2: invalid numbers leave store and staging alone
    load_stage(60);
    xfer(8'hF3, 33);
    check_stage("R2 staging after 33");
    verify_obj(1);
    load_stage(61);
    xfer(8'hF3, 0);
    check_stage("R2 staging after 0");
    verify_obj(32);
    load_stage(62);
    xfer(8'h7F, 40);
    check_stage("R2 staging after read of 40");

    // R3: second request during busy is dropped
    load_stage(70);
    cpu_wr(3'd0, 8'hF3);
    s_cmd = 8'hF3;
    req_valid = 1'b1; req_num = 6'd1;
    @(negedge clk);
    req_num = 6'd2;
    chk("R3 busy after accept", 64'(busy), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 busy second cycle", 64'(busy), 64'd1);
    @(negedge clk);
    chk("R3 busy falls on time", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R3 no restart", 64'(busy), 64'd0);
    m_msk[1] = s_msk; m_arb[1] = s_arb; m_ctl[1] = s_ctl; m_fl[1] = s_fl;
    m_a[1] = s_a; m_b[1] = s_b;
    verify_obj(2);
    verify_obj(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule